// File: doc/BRIEF.md
# Parallel Vector History Debouncer

This block removes contact bounce from a vector of raw digital inputs. It treats every bit the same way at the same time. It keeps no counter per bit. Instead it holds a short history of sampled input vectors in a shift register, and one combinational flip function covers the whole vector. The cost in logic grows only linearly with the width, and the response time does not depend on the width at all.

A clock divider turns the system clock into a one-cycle sample enable. Its period is set from the parameters `CLK_HZ` and `TICK_HZ` and must lie between 1/60 s and 1/30 s. On each enable, a freshly synchronized input vector enters the history and the oldest sample is dropped. In that same enable, the next debounced vector is computed as `y ^ ((y ^ s0) & (y ^ s1) & ...)`, where `s0` is the new sample and the later terms are the stored ones.

An output bit inverts only when all `DEPTH` of its most recent samples disagree with it. When a bit inverts, its change strobe pulses for one clock. Once a bit has flipped, it needs a full `DEPTH` run of opposite samples before it can flip back.

Top module: `vdb_debouncer`

## Requirements
- R1: While `rst` is high, and on the first clock after it is released, `deb_o` and `chg_o` are zero. Reset also clears the sample history, so samples taken before reset never count toward a later inversion.
- R2: A bit of `deb_o` inverts only on a sample enable where the newest sample of that bit and the `DEPTH-1` stored samples before it (default `DEPTH` = 3) all differ from its current value. In every other case the bit holds.
- R3: All bit positions are filtered at once and independently. A vector with a different value on each bit produces, on each bit, the result that bit alone would give.
- R4: After a bit inverts, it inverts back only after `DEPTH` further consecutive samples of the opposite level. A shorter run has no effect on that bit.
- R5: The sample enable recurs every `CLK_HZ/TICK_HZ` clocks, and it is high for exactly one clock at a time. `deb_o` changes only on a clock edge where the enable is high. With the default 3 samples, the first enable falls on the 11th clock edge after reset is released when `CLK_HZ/TICK_HZ` is 10.
- R6: The raw input passes through two flip-flops before it is sampled. The sample taken on an enable is included in that same enable's evaluation, so a raw level that has been steady for two clocks before the enable edge counts as a sample on that edge.
- R7: `chg_o` is high for one clock, right after the edge on which `deb_o` changes, on exactly the bits that inverted. It is zero at all other times.
- R8: Elaboration rejects `DEPTH` below 2, `WIDTH` below 1, `SYNC_STAGES` below 2, a `TICK_HZ` outside 30 to 60, and a divide ratio below 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| raw_i | input | WIDTH | Raw, asynchronous input vector |
| deb_o | output | WIDTH | Registered debounced vector |
| chg_o | output | WIDTH | One-clock strobe on each bit that just inverted |

## Verification
The bench drives the input once per sample period, at a fixed point between enables. It compares each result with a model that counts the run of consecutive samples that disagree with each bit.

The patterns are chosen so that each one separates a correct design from a specific fault:
- A clean step on all bits shows that the inversion comes on the third sample and not the second.
- A bounce that returns after two samples shows that a short run is ignored, which separates full agreement from majority voting.
- A vector with mixed values per bit exposes any coupling between bit positions.
- A short reverse run just after an inversion checks the hysteresis.
- Resetting after a partial run shows whether stale history survives reset.
- The output is read on the clock before each enable edge and on the clock after it. This confirms that changes happen only on enable edges and that the strobe lasts exactly one clock.

// File: rtl/vdb_pkg.sv
package vdb_pkg;
   // Number of system clocks in one sample period
   function automatic int unsigned tick_div(input longint unsigned clk_hz,
                                            input longint unsigned tick_hz);
      return int'(clk_hz / tick_hz);
   endfunction

   // Bits needed to count one sample period
   function automatic int unsigned div_bits(input int unsigned div);
      return (div < 2) ? 1 : $clog2(div);
   endfunction
endpackage

// File: rtl/vdb_tick_gen.sv
module vdb_tick_gen #(
   parameter int unsigned DIV = 10
) (
   input  logic clk,
   input  logic rst,
   output logic tick
);
   localparam int unsigned CW = vdb_pkg::div_bits(DIV);
   localparam logic [CW-1:0] LAST = CW'(DIV - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         cnt_q <= '0;
         tick  <= 1'b0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
         tick  <= 1'b1;
      end else begin
         cnt_q <= cnt_q + 1'b1;
         tick  <= 1'b0;
      end
   end
endmodule

// File: rtl/vdb_sync.sv
module vdb_sync #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stage_q [STAGES];

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (rst) stage_q[i] <= '0;
         else if (i == 0) stage_q[i] <= d;
         else stage_q[i] <= stage_q[(i == 0) ? 0 : i - 1];
      end
   end

   assign q = stage_q[STAGES-1];
endmodule

// File: rtl/vdb_flip_core.sv
module vdb_flip_core #(
   parameter int unsigned WIDTH = 8,
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             tick,
   input  logic [WIDTH-1:0] smp,
   output logic [WIDTH-1:0] y,
   output logic [WIDTH-1:0] chg
);
   localparam int unsigned NPREV = DEPTH - 1;

   logic [WIDTH-1:0] prev_q [NPREV];
   logic [WIDTH-1:0] term   [DEPTH];
   logic [WIDTH-1:0] flip;

   // Stored history: prev_q[0] is the sample before the newest one
   for (genvar i = 0; i < NPREV; i++) begin : g_hist
      always_ff @(posedge clk) begin
         if (rst) prev_q[i] <= '0;
         else if (tick) begin
            if (i == 0) prev_q[i] <= smp;
            else prev_q[i] <= prev_q[(i == 0) ? 0 : i - 1];
         end
      end
   end

   // Disagreement chain, the new sample taken first
   assign term[0] = y ^ smp;
   for (genvar i = 1; i < DEPTH; i++) begin : g_term
      assign term[i] = term[i-1] & (y ^ prev_q[i-1]);
   end
   assign flip = term[DEPTH-1];

   always_ff @(posedge clk) begin
      if (rst) begin
         y   <= '0;
         chg <= '0;
      end else if (tick) begin
         y   <= y ^ flip;
         chg <= flip;
      end else begin
         chg <= '0;
      end
   end
endmodule

// File: rtl/vdb_debouncer.sv
module vdb_debouncer #(
   parameter int unsigned    WIDTH       = 8,
   parameter int unsigned    DEPTH       = 3,
   parameter int unsigned    SYNC_STAGES = 2,
   parameter longint unsigned CLK_HZ     = 50_000_000,
   parameter longint unsigned TICK_HZ    = 50
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] deb_o,
   output logic [WIDTH-1:0] chg_o
);
   localparam int unsigned DIV = vdb_pkg::tick_div(CLK_HZ, TICK_HZ);

   // R8: parameter legality
   if (WIDTH < 1) begin : g_bad_width
      $error("vdb_debouncer: WIDTH must be at least 1");
   end
   if (DEPTH < 2) begin : g_bad_depth
      $error("vdb_debouncer: DEPTH must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("vdb_debouncer: SYNC_STAGES must be at least 2");
   end
   if (TICK_HZ < 30 || TICK_HZ > 60) begin : g_bad_rate
      $error("vdb_debouncer: TICK_HZ must lie in 30..60");
   end
   if (DIV < 2) begin : g_bad_div
      $error("vdb_debouncer: CLK_HZ/TICK_HZ must be at least 2");
   end

   logic             tick_en;
   logic [WIDTH-1:0] smp_sync;

   vdb_tick_gen #(.DIV(DIV)) u_tick (
      .clk (clk),
      .rst (rst),
      .tick(tick_en)
   );

   vdb_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
      .clk(clk),
      .rst(rst),
      .d  (raw_i),
      .q  (smp_sync)
   );

   vdb_flip_core #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_core (
      .clk (clk),
      .rst (rst),
      .tick(tick_en),
      .smp (smp_sync),
      .y   (deb_o),
      .chg (chg_o)
   );
endmodule

// File: rtl/vdb_debouncer_chk.sv
module vdb_debouncer_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic             clk,
   input logic             rst,
   input logic             tick,
   input logic [WIDTH-1:0] smp,
   input logic [WIDTH-1:0] y,
   input logic [WIDTH-1:0] chg
);
   assert_reset_clear_R1: assert property (@(posedge clk)
      rst |=> (y == '0 && chg == '0));

   assert_flip_matches_sample_R2: assert property (@(posedge clk) disable iff (rst)
      tick |=> (((y ^ $past(y)) & (y ^ $past(smp))) == '0));

   assert_hold_between_ticks_R5: assert property (@(posedge clk) disable iff (rst)
      !tick |=> $stable(y));

   assert_tick_single_R5: assert property (@(posedge clk) disable iff (rst)
      tick |=> !tick);

   assert_strobe_marks_change_R7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (chg == (y ^ $past(y))));

   assert_strobe_one_cycle_R7: assert property (@(posedge clk) disable iff (rst)
      (chg != '0) |=> (chg == '0));
endmodule

bind vdb_debouncer vdb_debouncer_chk #(.WIDTH(WIDTH)) u_chk (
   .clk (clk),
   .rst (rst),
   .tick(tick_en),
   .smp (smp_sync),
   .y   (deb_o),
   .chg (chg_o)
);

// File: tb/sim_vdb_debouncer.sv
`timescale 1ns/1ps
module sim_vdb_debouncer;
   localparam int W = 8;
   localparam int D = 3;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] raw_i = '0;
   logic [W-1:0] deb_o, chg_o;

   int checks = 0;
   int failures = 0;
   bit done = 0;

   // Reference state: value and run of disagreeing samples per bit
   logic [W-1:0] m_y;
   int           m_run [W];

   always #10 clk = ~clk;

   vdb_debouncer #(.WIDTH(W), .DEPTH(D), .SYNC_STAGES(2),
                   .CLK_HZ(400), .TICK_HZ(40)) u0 (
      .clk(clk), .rst(rst), .raw_i(raw_i), .deb_o(deb_o), .chg_o(chg_o));

   task automatic check(input string tag, input logic [W-1:0] act,
                        input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_y = '0;
      for (int b = 0; b < W; b++) m_run[b] = 0;
   endtask

   // Sample period of 10 clocks. Entered just after edge 5 of the period;
   // the enable edge is edge 11.
   task automatic do_sample(input logic [W-1:0] v, input string tag);
      logic [W-1:0] old_y, flipped;
      old_y = m_y;
      flipped = '0;
      for (int b = 0; b < W; b++) begin
         if (v[b] != m_y[b]) m_run[b]++;
         else m_run[b] = 0;
         if (m_run[b] >= D) begin
            flipped[b] = 1'b1;
            m_run[b] = 0;
         end
      end
      m_y = m_y ^ flipped;
      raw_i = v;
      repeat (5) @(posedge clk);
      @(negedge clk);
      check({tag, " R5 hold before enable"}, deb_o, old_y);
      @(posedge clk);
      @(negedge clk);
      check({tag, " R2 value"}, deb_o, m_y);
      check({tag, " R7 strobe"}, chg_o, flipped);
      repeat (4) @(posedge clk);
      @(negedge clk);
      check({tag, " R7 strobe cleared"}, chg_o, '0);
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 output zero in reset", deb_o, '0);
      check("R1 strobe zero in reset", chg_o, '0);
      rst = 1'b0;
      model_reset();
      repeat (5) @(posedge clk);
      @(negedge clk);
   endtask

   task automatic t_step_all();
      do_sample(8'hFF, "R6 step1");
      do_sample(8'hFF, "R6 step2");
      do_sample(8'hFF, "R2 step3 flips");
      check("R2 all ones", deb_o, 8'hFF);
   endtask

   task automatic t_bounce();
      do_sample(8'h00, "R2 bounce a");
      do_sample(8'h00, "R2 bounce b");
      do_sample(8'hFF, "R2 bounce back");
      check("R2 short run ignored", deb_o, 8'hFF);
      do_sample(8'h00, "R2 run1");
      do_sample(8'h00, "R2 run2");
      do_sample(8'h00, "R2 run3");
      check("R2 full run", deb_o, 8'h00);
   endtask

   task automatic t_mixed();
      do_sample(8'h5A, "R3 m1");
      do_sample(8'h5A, "R3 m2");
      do_sample(8'h5F, "R3 m3");
      check("R3 per bit", deb_o, 8'h5A);
      do_sample(8'h0F, "R3 m4");
      do_sample(8'h0F, "R3 m5");
      do_sample(8'h0F, "R3 m6");
   endtask

   task automatic t_hysteresis();
      logic [W-1:0] base;
      base = m_y;
      do_sample(~base, "R4 h1");
      do_sample(~base, "R4 h2");
      do_sample(~base, "R4 h3");
      check("R4 inverted", deb_o, ~base);
      do_sample(base, "R4 back1");
      do_sample(base, "R4 back2");
      do_sample(~base, "R4 interrupt");
      check("R4 held after short reverse run", deb_o, ~base);
      do_sample(base, "R4 r1");
      do_sample(base, "R4 r2");
      do_sample(base, "R4 r3");
      check("R4 returned", deb_o, base);
   endtask

   task automatic t_reset_history();
      model_reset();
      do_reset();
      do_sample(8'hFF, "R1 pre a");
      do_sample(8'hFF, "R1 pre b");
      do_reset();
      do_sample(8'hFF, "R1 after reset one sample");
      check("R1 history cleared", deb_o, 8'h00);
      do_sample(8'hFF, "R1 after reset two");
      do_sample(8'hFF, "R1 after reset three");
   endtask

   initial begin
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset output", deb_o, '0);
      check("R1 reset strobe", chg_o, '0);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      check("R1 output after release", deb_o, '0);
      repeat (4) @(posedge clk);
      @(negedge clk);
      t_step_all();
      t_bounce();
      t_mixed();
      t_hysteresis();
      t_reset_history();
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule